// File: doc/BRIEF.md
# Time-of-Day to Timebase Transfer Initiator

This block chooses which core should receive a copy of the chip time-of-day value, and then starts that copy when a command asks for it. Software writes a target-select register, which is offset 0x27 on the block's 6-bit register write port. That write names the destination core in one of two ways. The first is a full 32-bit register address, checked against a per-core base address table. The second is a small core number. The decoded core index and a valid flag are held until the next write to the same register.

A write to the move register, at offset 0x17, requests the transfer. Four conditions are checked in a fixed order:

- the time-of-day state controller reports running;
- the command bit in the written word is set;
- a valid target is latched;
- the chosen core says it is ready to receive.

If all four pass, the block raises a single-cycle strobe on that core's bit of the sent vector. If any one fails, the block raises a single-cycle error with a 2-bit code that names the first condition that failed. The time value itself and the core-side timebase logic belong to neighbouring blocks.

Top module: `tod_tb_xfer`

## Requirements
- R1: After reset, the latched target is invalid and the sent vector, the move error and the target error are all low.
- R2: A write to offset 0x27 with data bit 28 set uses full-address mode. The target address is data[63:32]. If its low 12 bits equal 0x4A3 and its upper 20 bits equal the upper 20 bits of the base address of core i, the block latches core i as valid on the next clock. The lowest matching index wins.
- R3: In full-address mode, a low 12-bit field other than 0x4A3 latches an invalid target and pulses the target error for one cycle.
- R4: In full-address mode, if no core base matches the upper 20 address bits, the block latches an invalid target and pulses the target error.
- R5: A write to offset 0x27 with bit 28 clear uses core-ID mode. The core number is data[36:32]. A number below the core count latches that core as valid. A number at or above the core count latches an invalid target and pulses the target error.
- R6: When core-ID mode is disabled by parameter, any core-ID write latches an invalid target and pulses the target error.
- R7: A move write whose four checks all pass produces a one-hot sent vector for the latched core. The strobe is high on the clock after the write and lasts one cycle, and no error is raised.
- R8: A move write while the controller is not running raises the move error with code 0 and sends nothing.
- R9: A move write with data bit 63 clear, while the controller is running, raises code 1 and sends nothing.
- R10: A move write when no valid target is latched, but the earlier checks pass, raises code 2 and sends nothing.
- R11: A move write whose target core has its ready bit low, but the earlier checks pass, raises code 3 and sends nothing.
- R12: When several conditions fail at once, the reported code is the lowest-numbered failing one (running, then command bit, then target, then ready).
- R13: A write to any other offset changes no latched target and produces no strobe or error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register offset of the write |
| wr_data | input | 64 | Write data |
| tod_running | input | 1 | Time-of-day controller is in the running state |
| core_ready | input | NCORES | Per-core ready-to-receive flags |
| sent_pulse | output | NCORES | One-hot single-cycle transfer strobe per core |
| move_err | output | 1 | Single-cycle pulse for a rejected move |
| move_err_code | output | 2 | Failed condition: 0 not running, 1 no command bit, 2 no target, 3 not ready |
| cfg_err | output | 1 | Single-cycle pulse for a target write that decoded to no core |
| tgt_valid | output | 1 | A valid target is latched |
| tgt_core | output | IDX_W | Latched target core index |

## Verification
The bench builds two instances with four cores and the default base table (0x20000000 plus core times 0x01000000), and drives both from the same write bus. One instance keeps core-ID mode enabled. That instance can reach the in-range and out-of-range core numbers (4 to 31), so the core-count boundary is covered. The other instance is built with core-ID mode disabled. There, every core-ID write must be rejected while full-address writes still decode the same way, so the two instances show the parameter's effect side by side. Random moves combine the running, command-bit, target and ready conditions in all mixes, which exercises the check order.

// File: rtl/tod_xfer_pkg.sv
package tod_xfer_pkg;

  // Reject reason for a move command, in checking order
  typedef enum logic [1:0] {
    XERR_IDLE_TOD = 2'd0,
    XERR_NO_CMD   = 2'd1,
    XERR_NO_TGT   = 2'd2,
    XERR_NOT_RDY  = 2'd3
  } xfer_err_e;

  // Bit positions in the 64-bit write word (LSB-0 numbering)
  localparam int unsigned MODE_BIT = 28;   // set: full-address mode
  localparam int unsigned CMD_BIT  = 63;   // move command bit
  localparam int unsigned ADDR_LO  = 32;   // target address occupies [63:32]
  localparam int unsigned ID_LO    = 32;   // core number occupies [36:32]

endpackage

// File: rtl/tod_xfer_decode.sv
module tod_xfer_decode #(
  parameter int unsigned NCORES     = 4,
  parameter int unsigned IDX_W      = 2,
  parameter logic [NCORES-1:0][31:0] CORE_BASE = '0,
  parameter bit          CORE_ID_EN = 1'b1,
  parameter logic [11:0] TGT_REG    = 12'h4A3
) (
  input  logic [63:0]      data,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  import tod_xfer_pkg::*;

  logic [31:0]       taddr;
  logic [4:0]        core_num;
  logic [NCORES-1:0] base_match;
  logic              fa_hit;
  logic [IDX_W-1:0]  fa_idx;

  assign taddr    = data[ADDR_LO +: 32];
  assign core_num = data[ID_LO +: 5];

  // One comparator per core against the base table
  for (genvar g = 0; g < NCORES; g++) begin : g_match
    assign base_match[g] = (taddr[31:12] == CORE_BASE[g][31:12]);
  end

  // Lowest matching core wins
  always_comb begin
    fa_idx = '0;
    for (int i = NCORES - 1; i >= 0; i--) begin
      if (base_match[i]) fa_idx = IDX_W'(i);
    end
    fa_hit = (taddr[11:0] == TGT_REG) && (|base_match);
  end

  always_comb begin
    if (data[MODE_BIT]) begin
      hit = fa_hit;
      idx = fa_idx;
    end else begin
      hit = CORE_ID_EN && ({1'b0, core_num} < 6'(NCORES));
      idx = IDX_W'(core_num);
    end
  end

endmodule

// File: rtl/tod_xfer_gate.sv
module tod_xfer_gate #(
  parameter int unsigned NCORES = 4,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              move_wr,
  input  logic              cmd_bit,
  input  logic              running,
  input  logic              tgt_valid,
  input  logic [IDX_W-1:0]  tgt_idx,
  input  logic [NCORES-1:0] core_ready,
  output logic [NCORES-1:0] sent_q,
  output logic              err_q,
  output logic [1:0]        code_q
);
  import tod_xfer_pkg::*;

  logic [NCORES-1:0] sent_d;
  logic              err_d;
  xfer_err_e         code_d;

  // Checks in fixed order; first failure names the code
  always_comb begin
    sent_d = '0;
    err_d  = 1'b0;
    code_d = XERR_IDLE_TOD;
    if (move_wr) begin
      if (!running) begin
        err_d  = 1'b1;
        code_d = XERR_IDLE_TOD;
      end else if (!cmd_bit) begin
        err_d  = 1'b1;
        code_d = XERR_NO_CMD;
      end else if (!tgt_valid) begin
        err_d  = 1'b1;
        code_d = XERR_NO_TGT;
      end else if (!core_ready[tgt_idx]) begin
        err_d  = 1'b1;
        code_d = XERR_NOT_RDY;
      end else begin
        sent_d[tgt_idx] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent_q <= '0;
      err_q  <= 1'b0;
      code_q <= 2'd0;
    end else begin
      sent_q <= sent_d;
      err_q  <= err_d;
      code_q <= code_d;
    end
  end

endmodule

// File: rtl/tod_tb_xfer.sv
module tod_tb_xfer #(
  parameter int unsigned NCORES     = 4,
  parameter int unsigned IDX_W      = (NCORES > 1) ? $clog2(NCORES) : 1,
  parameter logic [NCORES-1:0][31:0] CORE_BASE =
    {32'h2300_0000, 32'h2200_0000, 32'h2100_0000, 32'h2000_0000},
  parameter bit          CORE_ID_EN = 1'b1,
  parameter logic [5:0]  SEL_OFS    = 6'h27,
  parameter logic [5:0]  MOVE_OFS   = 6'h17,
  parameter logic [11:0] TGT_REG    = 12'h4A3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [5:0]        wr_addr,
  input  logic [63:0]       wr_data,
  input  logic              tod_running,
  input  logic [NCORES-1:0] core_ready,
  output logic [NCORES-1:0] sent_pulse,
  output logic              move_err,
  output logic [1:0]        move_err_code,
  output logic              cfg_err,
  output logic [IDX_W-1:0]  tgt_core,
  output logic              tgt_valid
);
  import tod_xfer_pkg::*;

  logic             sel_wr;
  logic             move_wr;
  logic             dec_hit;
  logic [IDX_W-1:0] dec_idx;
  logic             valid_d;
  logic [IDX_W-1:0] core_d;
  logic             cfg_err_d;

  assign sel_wr  = wr_en && (wr_addr == SEL_OFS);
  assign move_wr = wr_en && (wr_addr == MOVE_OFS);

  tod_xfer_decode #(
    .NCORES(NCORES), .IDX_W(IDX_W), .CORE_BASE(CORE_BASE),
    .CORE_ID_EN(CORE_ID_EN), .TGT_REG(TGT_REG)
  ) u_dec (
    .data(wr_data),
    .hit (dec_hit),
    .idx (dec_idx)
  );

  // Target register next state, enabled by a select write
  always_comb begin
    valid_d   = tgt_valid;
    core_d    = tgt_core;
    cfg_err_d = 1'b0;
    if (sel_wr) begin
      valid_d   = dec_hit;
      core_d    = dec_idx;
      cfg_err_d = !dec_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_valid <= 1'b0;
      tgt_core  <= '0;
      cfg_err   <= 1'b0;
    end else begin
      tgt_valid <= valid_d;
      tgt_core  <= core_d;
      cfg_err   <= cfg_err_d;
    end
  end

  tod_xfer_gate #(.NCORES(NCORES), .IDX_W(IDX_W)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .move_wr   (move_wr),
    .cmd_bit   (wr_data[CMD_BIT]),
    .running   (tod_running),
    .tgt_valid (tgt_valid),
    .tgt_idx   (tgt_core),
    .core_ready(core_ready),
    .sent_q    (sent_pulse),
    .err_q     (move_err),
    .code_q    (move_err_code)
  );

endmodule

// File: rtl/tod_xfer_chk.sv
module tod_xfer_chk #(
  parameter int unsigned NCORES   = 4,
  parameter int unsigned IDX_W    = 2,
  parameter logic [5:0]  MOVE_OFS = 6'h17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [5:0]        wr_addr,
  input logic              tod_running,
  input logic [NCORES-1:0] sent_pulse,
  input logic              move_err,
  input logic [1:0]        move_err_code,
  input logic              cfg_err,
  input logic [IDX_W-1:0]  tgt_core,
  input logic              tgt_valid
);
  logic [NCORES-1:0] tgt_sel;
  assign tgt_sel = NCORES'(1) << tgt_core;

  // R7
  sent_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sent_pulse));

  // R7
  sent_to_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|sent_pulse) |-> (tgt_valid && sent_pulse == tgt_sel));

  // R7
  sent_xor_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(move_err && (|sent_pulse)));

  // R8
  idle_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == MOVE_OFS && !tod_running)
      |=> (move_err && move_err_code == 2'd0 && sent_pulse == '0));

  // R13
  no_move_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == MOVE_OFS) |=> (sent_pulse == '0 && !move_err));

  // R3
  cfg_err_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !tgt_valid);

endmodule

bind tod_tb_xfer tod_xfer_chk #(
  .NCORES(NCORES), .IDX_W(IDX_W), .MOVE_OFS(MOVE_OFS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .tod_running  (tod_running),
  .sent_pulse   (sent_pulse),
  .move_err     (move_err),
  .move_err_code(move_err_code),
  .cfg_err      (cfg_err),
  .tgt_core     (tgt_core),
  .tgt_valid    (tgt_valid)
);

// File: tb/tod_tb_xfer_tb.sv
module tod_tb_xfer_tb;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [5:0]   wr_addr = '0;
  logic [63:0]  wr_data = '0;
  logic         tod_running = 1'b0;
  logic [N-1:0] core_ready = '0;

  logic [N-1:0] sent_a, sent_b;
  logic         merr_a, merr_b, cerr_a, cerr_b, tv_a, tv_b;
  logic [1:0]   code_a, code_b, tc_a, tc_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Model state per instance: a = core-ID enabled, b = disabled
  bit ev_a = 0, ev_b = 0;
  int ec_a = 0, ec_b = 0;

  always #2 clk = ~clk;

  tod_tb_xfer #(.NCORES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tod_running(tod_running), .core_ready(core_ready), .sent_pulse(sent_a),
    .move_err(merr_a), .move_err_code(code_a), .cfg_err(cerr_a),
    .tgt_core(tc_a), .tgt_valid(tv_a));

  tod_tb_xfer #(.NCORES(N), .CORE_ID_EN(1'b0)) u_dut_fa (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tod_running(tod_running), .core_ready(core_ready), .sent_pulse(sent_b),
    .move_err(merr_b), .move_err_code(code_b), .cfg_err(cerr_b),
    .tgt_core(tc_b), .tgt_valid(tv_b));

  function automatic logic [31:0] base_of(input int i);
    return 32'h2000_0000 + (32'(i) << 24);
  endfunction

  function automatic void exp_dec(input logic [63:0] d, input bit id_en,
                                  output bit v, output int c);
    v = 0; c = 0;
    if (d[28]) begin
      if (d[43:32] == 12'h4A3)
        for (int i = 0; i < N; i++)
          if (!v && d[63:44] == base_of(i)[31:12]) begin v = 1; c = i; end
    end else begin
      c = int'(d[36:32]);
      v = id_en && (c < N);
    end
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Check one instance after a move
  task automatic chk_move(input string tag, input bit run, input bit cmd, input bit v,
                          input int c, input logic [N-1:0] sent,
                          input logic merr, input logic [1:0] code);
    logic [1:0] ec;
    bit         ok_send;
    ok_send = 0;
    if (!run) ec = 2'd0;
    else if (!cmd) ec = 2'd1;
    else if (!v) ec = 2'd2;
    else if (!core_ready[c]) ec = 2'd3;
    else begin ec = 2'd0; ok_send = 1; end
    if (ok_send) begin
      chk(sent == (N'(1) << c) && !merr, "R7", {tag, " sent"}, 64'(sent), 64'(N'(1) << c));
    end else begin
      chk(sent == '0 && merr, "R12", {tag, " reject"}, 64'({merr, sent}), 64'(1 << N));
      if (ec == 2'd0) chk(code == ec, "R8", {tag, " code"}, 64'(code), 64'(ec));
      else if (ec == 2'd1) chk(code == ec, "R9", {tag, " code"}, 64'(code), 64'(ec));
      else if (ec == 2'd2) chk(code == ec, "R10", {tag, " code"}, 64'(code), 64'(ec));
      else chk(code == ec, "R11", {tag, " code"}, 64'(code), 64'(ec));
    end
  endtask

  task automatic chk_tgt(input string req, input string tag, input bit v, input int c,
                         input logic tv, input logic [1:0] tc, input logic ce,
                         input bit sel_wr);
    chk(tv == v, req, {tag, " valid"}, 64'(tv), 64'(v));
    if (v) chk(tc == 2'(c), req, {tag, " core"}, 64'(tc), 64'(c));
    chk(ce == (sel_wr && !v), req, {tag, " cfg_err"}, 64'(ce), 64'(sel_wr && !v));
  endtask

  // One write cycle, then check at the following negedge
  task automatic do_op(input string req, input logic [5:0] a, input logic [63:0] d,
                       input bit run, input logic [N-1:0] rdy);
    bit va, vb; int ca, cb;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tod_running = run; core_ready = rdy;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 6'h27) begin
      exp_dec(d, 1'b1, va, ca); exp_dec(d, 1'b0, vb, cb);
      ev_a = va; ec_a = ca; ev_b = vb; ec_b = cb;
      chk_tgt(req, "a", ev_a, ec_a, tv_a, tc_a, cerr_a, 1'b1);
      chk_tgt(d[28] ? req : "R6", "b", ev_b, ec_b, tv_b, tc_b, cerr_b, 1'b1);
    end else if (a == 6'h17) begin
      chk_move("a", run, d[63], ev_a, ec_a, sent_a, merr_a, code_a);
      chk_move("b", run, d[63], ev_b, ec_b, sent_b, merr_b, code_b);
    end else begin
      chk_tgt("R13", "a", ev_a, ec_a, tv_a, tc_a, cerr_a, 1'b0);
      chk_tgt("R13", "b", ev_b, ec_b, tv_b, tc_b, cerr_b, 1'b0);
      chk(sent_a == '0 && !merr_a && sent_b == '0 && !merr_b, "R13", "quiet",
          64'({sent_a, sent_b}), 64'(0));
    end
  endtask

  function automatic logic [63:0] fa_word(input logic [31:0] addr);
    return {addr, 32'h1000_0000};
  endfunction

  function automatic logic [63:0] id_word(input int id);
    return {26'd0, 6'(id), 32'h0};
  endfunction

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(!tv_a && sent_a == '0 && !merr_a && !cerr_a, "R1", "reset a",
        64'({tv_a, sent_a, merr_a, cerr_a}), 64'(0));
    chk(!tv_b && sent_b == '0 && !merr_b && !cerr_b, "R1", "reset b",
        64'({tv_b, sent_b, merr_b, cerr_b}), 64'(0));
    rst_n = 1'b1;

    // Directed corner cases
    do_op("R10", 6'h17, 64'h8000_0000_0000_0000, 1'b1, 4'hF);
    do_op("R2", 6'h27, fa_word(base_of(2) | 32'h4A3), 1'b0, 4'h0);
    do_op("R7", 6'h17, 64'h8000_0000_0000_0000, 1'b1, 4'h4);
    do_op("R11", 6'h17, 64'h8000_0000_0000_0000, 1'b1, 4'hB);
    do_op("R9", 6'h17, 64'h0, 1'b1, 4'hF);
    do_op("R8", 6'h17, 64'h0, 1'b0, 4'h0);
    do_op("R13", 6'h18, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 4'hF);
    do_op("R3", 6'h27, fa_word(base_of(1) | 32'h4A4), 1'b0, 4'h0);
    do_op("R4", 6'h27, fa_word(32'h7000_04A3), 1'b0, 4'h0);
    do_op("R5", 6'h27, id_word(3), 1'b0, 4'h0);
    do_op("R7", 6'h17, 64'h8000_0000_0000_0000, 1'b1, 4'h8);
    do_op("R5", 6'h27, id_word(4), 1'b0, 4'h0);
    do_op("R5", 6'h27, id_word(31), 1'b0, 4'h0);
    do_op("R5", 6'h27, id_word(0), 1'b0, 4'h0);

    // Random mix
    for (int k = 0; k < 400; k++) begin
      int sel; logic [63:0] d; logic [5:0] a; int ci;
      sel = int'($urandom_range(0, 9));
      ci  = int'($urandom_range(0, N - 1));
      d   = {$urandom, $urandom};
      if (sel < 2) begin
        a = 6'h27; d = fa_word(base_of(ci) | 32'h4A3);
      end else if (sel == 2) begin
        a = 6'h27; d[28] = 1'b1;
      end else if (sel == 3) begin
        a = 6'h27; d = id_word(int'($urandom_range(0, 7)));
      end else if (sel < 9) begin
        a = 6'h17;
      end else begin
        a = 6'($urandom_range(0, 63));
        if (a == 6'h27 || a == 6'h17) a = 6'h00;
      end
      do_op("R12", a, d, 1'($urandom), 4'($urandom));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule